// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Byte Access Master

This block is the master side of a two-wire serial link to a serial EEPROM inside the same chip. A host hands it one command at a time. There are three commands: store one byte at a given word address, fetch the byte at the EEPROM's own address pointer, or fetch the byte at a given word address. The block produces the clock line with a push-pull output. It pulls the data line low or lets it go, and it reads the resolved line level back to collect read data and acknowledge bits.

Each command runs through a fixed list of bus steps. The steps are start, send byte, check acknowledge, receive byte, master not-acknowledge and stop. The sequencer issues one step at a time from a step table and waits for each step to finish. When the EEPROM does not acknowledge, the block takes it to be still busy with an earlier internal write. It then closes the frame with a stop and reports failure. It does not retry. A random-address read first writes the word address without data. It then issues a repeated start and a read control byte.

The bit rate is set by a parameter, `QTR_CYC`, which is the number of clock cycles in each quarter of a bit period. The host keeps track of progress through `busy_o` and a one-cycle `done_o` pulse. The `pass_o` and `rdata_o` outputs carry the result.

Top module: `eep_byte_master`

## Requirements
- R1: While `rst_ni` is low and after it is released, `scl_o` and `sda_o` are 1, and `busy_o` and `done_o` are 0.
- R2: A command with `cmd_op_i` 0, 1 or 2 is accepted when `cmd_valid_i` is high at a clock edge while `busy_o` is low, and `busy_o` is high from the next cycle on. `busy_o` falls in the same cycle that `done_o` pulses high, and `done_o` lasts one cycle.
- R3: `cmd_op_i` = 3 is reserved. It is ignored: `busy_o` stays low, no `done_o` pulse follows, and both bus lines stay at 1.
- R4: `cmd_valid_i` is ignored while `busy_o` is high. The running command finishes with its own result, and the ignored command produces no second `done_o` and has no effect on the EEPROM.
- R5: Op 0 (write) sends, inside one frame, a start, then control byte 0xA0 (device type 1010, chip select 000, bit 0 = 0 for write), then the word address, then the data byte, then a stop. Each byte goes MSB first and is followed by an acknowledge check. On success `pass_o` = 1.
- R6: Op 1 (read at the current address) sends a start and control byte 0xA1 (bit 0 = 1 for read). It then receives 8 bits MSB first, leaves `sda_o` at 1 during the ninth clock (not-acknowledge), and ends with a stop. `rdata_o` holds the received byte with `pass_o` = 1.
- R7: Op 2 (read at a given address) sends a start, 0xA0 and the word address. It then sends a repeated start and 0xA1, and finishes as in R6. After the command, the EEPROM's address pointer is at the given address plus one.
- R8: If any acknowledge bit is sampled high, the block sends no further byte, ends the frame with a stop, and reports `done_o` with `pass_o` = 0.
- R9: While `scl_o` is high, `sda_o` changes only inside a start (it falls) or a stop (it rises). No other start or stop conditions appear: a command makes one start (two for op 2) and one stop.
- R10: Every high period of `scl_o` during a command lasts exactly 2·`QTR_CYC` cycles, except the idle high period at the end of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 2 | 0 write, 1 read current, 2 read random, 3 reserved |
| cmd_addr_i | input | 8 | Word address for ops 0 and 2 |
| cmd_wdata_i | input | 8 | Data byte for op 0 |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result: 1 success, 0 no acknowledge |
| rdata_o | output | 8 | Byte read by ops 1 and 2 |
| scl_o | output | 1 | Serial clock, push-pull |
| sda_o | output | 1 | Data line control: 0 pulls low, 1 releases |
| sda_i | input | 1 | Resolved data line level |

## Verification
The bench runs a bit-level EEPROM model on the wired-AND data line. The model keeps its own memory and address pointer, and it can be told to refuse acknowledges. Writes to the lowest and highest addresses, with data values of all ones, all zeros and mixed bits, followed by random and current reads, show whether MSB ordering is right, whether the address pointer wraps and advances, and whether a write has landed. Refused acknowledges on writes and random reads separate the abort path from the success path. A command issued while the block is busy, and the reserved op, check that ignored requests touch neither the bus nor the memory. Counts of start and stop conditions, the control bytes the model receives, the not-acknowledge seen by the model and the measured clock-high widths check the framing.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);
  localparam int STEP_IDX_W = 4;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [1:0] {OP_WRITE = 2'd0, OP_RD_CUR = 2'd1, OP_RD_RAND = 2'd2, OP_RSVD = 2'd3} op_e;
  typedef enum logic [2:0] {K_START, K_TX, K_ACK, K_RX, K_NACK, K_STOP, K_END} kind_e;
  typedef enum logic [1:0] {SRC_CW, SRC_CR, SRC_ADDR, SRC_DATA} src_e;

  typedef struct packed {
    kind_e kind;
    src_e  src;
  } step_t;

  function automatic step_t mk(kind_e k, src_e s);
    step_t r;
    r.kind = k;
    r.src  = s;
    return r;
  endfunction

  // Ordered bus steps per command
  function automatic step_t step_at(op_e op, logic [STEP_IDX_W-1:0] idx);
    step_t r;
    r = mk(K_END, SRC_CW);
    case (op)
      OP_WRITE: case (idx)
        4'd0: r = mk(K_START, SRC_CW);
        4'd1: r = mk(K_TX, SRC_CW);
        4'd2: r = mk(K_ACK, SRC_CW);
        4'd3: r = mk(K_TX, SRC_ADDR);
        4'd4: r = mk(K_ACK, SRC_CW);
        4'd5: r = mk(K_TX, SRC_DATA);
        4'd6: r = mk(K_ACK, SRC_CW);
        4'd7: r = mk(K_STOP, SRC_CW);
        default: r = mk(K_END, SRC_CW);
      endcase
      OP_RD_CUR: case (idx)
        4'd0: r = mk(K_START, SRC_CW);
        4'd1: r = mk(K_TX, SRC_CR);
        4'd2: r = mk(K_ACK, SRC_CW);
        4'd3: r = mk(K_RX, SRC_CW);
        4'd4: r = mk(K_NACK, SRC_CW);
        4'd5: r = mk(K_STOP, SRC_CW);
        default: r = mk(K_END, SRC_CW);
      endcase
      OP_RD_RAND: case (idx)
        4'd0: r = mk(K_START, SRC_CW);
        4'd1: r = mk(K_TX, SRC_CW);
        4'd2: r = mk(K_ACK, SRC_CW);
        4'd3: r = mk(K_TX, SRC_ADDR);
        4'd4: r = mk(K_ACK, SRC_CW);
        4'd5: r = mk(K_START, SRC_CW);
        4'd6: r = mk(K_TX, SRC_CR);
        4'd7: r = mk(K_ACK, SRC_CW);
        4'd8: r = mk(K_RX, SRC_CW);
        4'd9: r = mk(K_NACK, SRC_CW);
        4'd10: r = mk(K_STOP, SRC_CW);
        default: r = mk(K_END, SRC_CW);
      endcase
      default: r = mk(K_END, SRC_CW);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/eep_tick_gen.sv
module eep_tick_gen #(
  parameter int QTR_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CNT_W = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QTR_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  // R10
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  // R10
  cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/eep_bit_phy.sv
module eep_bit_phy
  import eep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              go_i,
  input  kind_e             go_kind_i,
  input  logic [BYTE_W-1:0] go_byte_i,
  input  logic              sda_i,
  output logic              active_o,
  output logic              done_o,
  output logic              ack_ok_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              scl_o,
  output logic              sda_o
);
  localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(BYTE_W - 1);

  logic                 active_q, done_q, ack_ok_q, scl_q, sda_q;
  logic [1:0]           ph_q;
  logic [BIT_IDX_W-1:0] bit_q;
  kind_e                kind_q;
  logic [BYTE_W-1:0]    tx_q, rx_q;
  logic                 last_bit;
  logic [BIT_IDX_W-1:0] nb;

  // {scl, sda} for a phase of the given step
  function automatic logic [1:0] pin_lvl(kind_e k, logic [1:0] ph, logic b);
    logic [1:0] r;
    case (k)
      K_START: case (ph)
        2'd0: r = 2'b01;
        2'd1: r = 2'b11;
        2'd2: r = 2'b10;
        default: r = 2'b00;
      endcase
      K_STOP: case (ph)
        2'd0: r = 2'b00;
        2'd1: r = 2'b10;
        default: r = 2'b11;
      endcase
      default: r = {(ph == 2'd1) || (ph == 2'd2), b};
    endcase
    return r;
  endfunction

  function automatic logic bit_lvl(kind_e k, logic [BYTE_W-1:0] tx, logic [BIT_IDX_W-1:0] i);
    return (k == K_TX) ? tx[LAST_BIT - i] : 1'b1;
  endfunction

  assign last_bit = ((kind_q == K_TX) || (kind_q == K_RX)) ? (bit_q == LAST_BIT) : 1'b1;
  assign nb       = bit_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      ack_ok_q <= 1'b0;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      ph_q     <= '0;
      bit_q    <= '0;
      kind_q   <= K_STOP;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        active_q       <= 1'b1;
        ph_q           <= '0;
        bit_q          <= '0;
        kind_q         <= go_kind_i;
        tx_q           <= go_byte_i;
        {scl_q, sda_q} <= pin_lvl(go_kind_i, 2'd0, bit_lvl(go_kind_i, go_byte_i, '0));
      end else if (active_q && tick_i) begin
        if (ph_q == 2'd1) begin  // sample while clock is high
          if (kind_q == K_RX)  rx_q     <= {rx_q[BYTE_W-2:0], sda_i};
          if (kind_q == K_ACK) ack_ok_q <= !sda_i;
        end
        if (ph_q == 2'd3) begin
          if (last_bit) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q          <= nb;
            ph_q           <= '0;
            {scl_q, sda_q} <= pin_lvl(kind_q, 2'd0, bit_lvl(kind_q, tx_q, nb));
          end
        end else begin
          ph_q           <= ph_q + 2'd1;
          {scl_q, sda_q} <= pin_lvl(kind_q, ph_q + 2'd1, bit_lvl(kind_q, tx_q, bit_q));
        end
      end
    end
  end

  assign active_o  = active_q;
  assign done_o    = done_q;
  assign ack_ok_o  = ack_ok_q;
  assign rx_byte_o = rx_q;
  assign scl_o     = scl_q;
  assign sda_o     = sda_q;

  // R9
  sda_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q) && scl_q && $past(scl_q) &&
     kind_q != K_START && kind_q != K_STOP) |-> $stable(sda_q));
  // R2
  go_when_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !active_q);
endmodule

// File: rtl/eep_byte_master.sv
module eep_byte_master
  import eep_pkg::*;
#(
  parameter int         QTR_CYC  = 4,
  parameter logic [2:0] CHIP_SEL = 3'b000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [BYTE_W-1:0] cmd_addr_i,
  input  logic [BYTE_W-1:0] cmd_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              scl_o,
  output logic              sda_o,
  input  logic              sda_i
);
  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_ABORT, S_ABORT_WAIT} seq_e;

  localparam logic [BYTE_W-1:0] CTRL_W = {DEV_TYPE, CHIP_SEL, 1'b0};
  localparam logic [BYTE_W-1:0] CTRL_R = {DEV_TYPE, CHIP_SEL, 1'b1};

  seq_e                  st_q;
  op_e                   op_q;
  logic [BYTE_W-1:0]     addr_q, data_q, rdata_q;
  logic [STEP_IDX_W-1:0] idx_q;
  logic                  done_q, pass_q;
  step_t                 cur;
  logic                  go;
  kind_e                 go_kind;
  logic [BYTE_W-1:0]     go_byte;
  logic                  tick, phy_active, phy_done, phy_ack_ok;
  logic [BYTE_W-1:0]     phy_rx;
  op_e                   cmd_op;

  assign cmd_op = op_e'(cmd_op_i);
  assign cur    = step_at(op_q, idx_q);

  always_comb begin
    go      = 1'b0;
    go_kind = cur.kind;
    case (cur.src)
      SRC_CW:   go_byte = CTRL_W;
      SRC_CR:   go_byte = CTRL_R;
      SRC_ADDR: go_byte = addr_q;
      default:  go_byte = data_q;
    endcase
    if (st_q == S_ISSUE && cur.kind != K_END) go = 1'b1;
    if (st_q == S_ABORT) begin
      go      = 1'b1;
      go_kind = K_STOP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      op_q    <= OP_WRITE;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (cmd_valid_i && cmd_op != OP_RSVD) begin
          op_q    <= cmd_op;
          addr_q  <= cmd_addr_i;
          data_q  <= cmd_wdata_i;
          idx_q   <= '0;
          rdata_q <= '0;
          st_q    <= S_ISSUE;
        end
        S_ISSUE: if (cur.kind == K_END) begin
          st_q   <= S_IDLE;
          done_q <= 1'b1;
          pass_q <= 1'b1;
        end else st_q <= S_WAIT;
        S_WAIT: if (phy_done) begin
          if (cur.kind == K_ACK && !phy_ack_ok) st_q <= S_ABORT;
          else begin
            if (cur.kind == K_RX) rdata_q <= phy_rx;
            idx_q <= idx_q + 1'b1;
            st_q  <= S_ISSUE;
          end
        end
        S_ABORT: st_q <= S_ABORT_WAIT;
        S_ABORT_WAIT: if (phy_done) begin
          st_q   <= S_IDLE;
          done_q <= 1'b1;
          pass_q <= 1'b0;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  eep_tick_gen #(.QTR_CYC(QTR_CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (phy_active),
    .tick_o (tick)
  );

  eep_bit_phy u_phy (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .go_i      (go),
    .go_kind_i (go_kind),
    .go_byte_i (go_byte),
    .sda_i     (sda_i),
    .active_o  (phy_active),
    .done_o    (phy_done),
    .ack_ok_o  (phy_ack_ok),
    .rx_byte_o (phy_rx),
    .scl_o     (scl_o),
    .sda_o     (sda_o)
  );

  assign busy_o  = (st_q != S_IDLE);
  assign done_o  = done_q;
  assign pass_o  = pass_q;
  assign rdata_o = rdata_q;

  // R2
  busy_end_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R2
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R1
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (scl_o && sda_o));
  // R4
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_valid_i) |=> ($stable(addr_q) && $stable(data_q)));
  // R8
  nack_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_WAIT && phy_done && cur.kind == K_ACK && !phy_ack_ok) |=>
    (go && go_kind == K_STOP));
endmodule

// File: tb/eep_byte_master_tb_top.sv
`timescale 1ns/1ps
module eep_byte_master_tb_top;
  localparam int QTR = 3;

  typedef struct {
    bit         pass;
    bit         has_rd;
    logic [7:0] rd;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [7:0] cmd_addr = '0, cmd_wdata = '0;
  logic       busy_o, done_o, pass_o, scl_o, sda_o;
  logic [7:0] rdata_o;
  logic       slv_low = 1'b0;
  logic       sda_bus;

  always #4 clk = ~clk;
  assign sda_bus = sda_o & ~slv_low;

  eep_byte_master #(.QTR_CYC(QTR), .CHIP_SEL(3'b000)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .busy_o(busy_o), .done_o(done_o),
    .pass_o(pass_o), .rdata_o(rdata_o), .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_bus)
  );

  int checks = 0, fails = 0, dones = 0;
  exp_t sb_q[$];
  logic [7:0] ref_mem[256];
  logic [7:0] ref_ptr = 8'h00;

  function automatic logic [7:0] seed(int i);
    return 8'(i * 7) ^ 8'hA5;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // EEPROM model on the wired-AND line
  logic [7:0] smem[256];
  logic [7:0] s_ptr = 8'h00, s_sh = 8'h00, s_txb = 8'h00, ctrl_last = 8'h00;
  logic       p_scl = 1'b1, p_sda = 1'b1, s_act = 1'b0, s_rd = 1'b0, in_ack = 1'b0;
  logic       slv_busy = 1'b0, nack_seen = 1'b0;
  int         s_mode = 0, s_bcnt = 0, starts = 0, stops = 0;

  initial begin
    for (int i = 0; i < 256; i++) begin
      smem[i]    = seed(i);
      ref_mem[i] = seed(i);
    end
  end

  always @(negedge clk) begin
    logic scl, sda;
    scl = scl_o;
    sda = sda_bus;
    if (scl && p_scl && p_sda && !sda) begin
      starts++; s_act = 1; s_mode = 0; s_bcnt = 0; in_ack = 0; slv_low = 0;
    end else if (scl && p_scl && !p_sda && sda) begin
      stops++; s_act = 0; slv_low = 0;
    end else if (s_act && scl && !p_scl) begin
      if (s_mode < 3 && s_bcnt < 8) begin
        s_sh = {s_sh[6:0], sda};
        s_bcnt++;
      end
      if (s_mode == 3 && s_bcnt == 8) nack_seen = sda;
    end else if (s_act && !scl && p_scl) begin
      if (s_mode < 3 && s_bcnt == 8 && !in_ack) begin
        if (s_mode == 0) begin
          ctrl_last = s_sh;
          if (slv_busy || s_sh[7:1] != 7'b1010000) s_mode = 4;
          else begin s_rd = s_sh[0]; in_ack = 1; slv_low = 1; end
        end else begin
          if (s_mode == 1) s_ptr = s_sh;
          else begin smem[s_ptr] = s_sh; s_ptr++; end
          in_ack = 1; slv_low = 1;
        end
      end else if (in_ack) begin
        in_ack = 0; slv_low = 0; s_bcnt = 0;
        if (s_mode == 0 && s_rd) begin
          s_mode = 3; s_txb = smem[s_ptr]; s_ptr++; slv_low = ~s_txb[7];
        end else if (s_mode < 2) s_mode++;
      end else if (s_mode == 3) begin
        s_bcnt++;
        slv_low = (s_bcnt < 8) ? ~s_txb[7 - s_bcnt] : 1'b0;
      end
    end
    p_scl = scl;
    p_sda = sda;
  end

  // SCL high width monitor (R10)
  int  hi_len = 0, bad_hi = 0, good_hi = 0;
  logic m_scl = 1'b1, m_busy = 1'b0, skip_fall = 1'b0;
  always @(negedge clk) begin
    if (busy_o && !m_busy) skip_fall = 1;
    if (m_scl && !scl_o) begin
      if (busy_o) begin
        if (skip_fall) skip_fall = 0;
        else if (hi_len != 2 * QTR) bad_hi++;
        else good_hi++;
      end
      hi_len = 0;
    end
    if (scl_o) hi_len++;
    m_scl = scl_o;
    m_busy = busy_o;
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb_q.size() == 0) chk(0, "R4", "unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(pass_o == e.pass, e.req, "pass", int'(pass_o), int'(e.pass));
        if (e.has_rd) chk(rdata_o == e.rd, e.req, "rdata", int'(rdata_o), int'(e.rd));
        chk(!busy_o, "R2", "busy at done", int'(busy_o), 0);
      end
      dones++;
    end
  end

  task automatic run(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d,
                     input bit refuse, input bit intrude, input string req);
    exp_t e;
    int s0, p0, target, exp_starts;
    e.pass = !refuse; e.has_rd = 0; e.rd = '0; e.req = req;
    if (!refuse) begin
      case (op)
        2'd0: begin ref_mem[a] = d; ref_ptr = a + 8'd1; end
        2'd1: begin e.has_rd = 1; e.rd = ref_mem[ref_ptr]; ref_ptr++; end
        default: begin e.has_rd = 1; e.rd = ref_mem[a]; ref_ptr = a + 8'd1; end
      endcase
    end
    sb_q.push_back(e);
    slv_busy = refuse; nack_seen = 0;
    s0 = starts; p0 = stops; target = dones + 1;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0;
    chk(busy_o == 1, "R2", "busy after accept", int'(busy_o), 1);
    if (intrude) begin
      repeat (40) @(negedge clk);
      cmd_valid = 1; cmd_op = 2'd0; cmd_addr = 8'h11; cmd_wdata = 8'h22;
      @(negedge clk);
      cmd_valid = 0;
    end
    while (dones < target) @(negedge clk);
    chk(done_o == 0, "R2", "done one cycle", int'(done_o), 0);
    exp_starts = (!refuse && op == 2'd2) ? 2 : 1;
    chk(starts - s0 == exp_starts, "R9", "start count", starts - s0, exp_starts);
    chk(stops - p0 == 1, "R9", "stop count", stops - p0, 1);
    if (!refuse) begin
      chk(ctrl_last == ((op == 2'd0) ? 8'hA0 : 8'hA1), req, "control byte",
          int'(ctrl_last), (op == 2'd0) ? 'hA0 : 'hA1);
      if (op != 2'd0) chk(nack_seen == 1, "R6", "master nack", int'(nack_seen), 1);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    chk(scl_o == 1, "R1", "scl in reset", int'(scl_o), 1);
    chk(sda_o == 1, "R1", "sda in reset", int'(sda_o), 1);
    chk(busy_o == 0, "R1", "busy in reset", int'(busy_o), 0);
    chk(done_o == 0, "R1", "done in reset", int'(done_o), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(scl_o == 1 && sda_o == 1, "R1", "bus idle after reset", int'({scl_o, sda_o}), 3);

    // R3: reserved op
    d0 = dones;
    cmd_valid = 1; cmd_op = 2'd3; cmd_addr = 8'h40;
    @(negedge clk);
    cmd_valid = 0;
    repeat (6) @(negedge clk);
    chk(busy_o == 0, "R3", "busy on reserved op", int'(busy_o), 0);
    chk(scl_o == 1 && sda_o == 1, "R3", "bus on reserved op", int'({scl_o, sda_o}), 3);
    chk(dones == d0, "R3", "done on reserved op", dones - d0, 0);

    run(2'd0, 8'h3C, 8'h96, 0, 0, "R5");
    run(2'd1, 8'h00, 8'h00, 0, 0, "R6");
    run(2'd2, 8'h3C, 8'h00, 0, 0, "R7");
    run(2'd1, 8'h00, 8'h00, 0, 0, "R6");
    run(2'd0, 8'hFF, 8'h00, 0, 0, "R5");
    run(2'd2, 8'hFF, 8'h00, 0, 0, "R7");
    run(2'd1, 8'h00, 8'h00, 0, 0, "R6");
    run(2'd0, 8'h00, 8'hFF, 0, 0, "R5");
    run(2'd2, 8'h00, 8'h00, 0, 0, "R7");
    // R8: refused acknowledges
    run(2'd0, 8'h3C, 8'h01, 1, 0, "R8");
    run(2'd2, 8'h3C, 8'h00, 1, 0, "R8");
    run(2'd2, 8'h3C, 8'h00, 0, 0, "R8");
    // R4: request during a busy command
    run(2'd2, 8'h80, 8'h00, 0, 1, "R4");
    run(2'd2, 8'h11, 8'h00, 0, 0, "R4");
    chk(sb_q.size() == 0, "R4", "pending results", sb_q.size(), 0);

    chk(bad_hi == 0 && good_hi > 0, "R10", "scl high width", bad_hi, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule